// File: doc/BRIEF.md
# Byte/Word Aliased General Register File

This block holds eight 16-bit general registers for a small processor core. Each register can act as a data operand or as a memory address. A register can be read or written as a whole word or through either of its two byte halves. Together the halves give sixteen byte-wide registers that share storage with the eight words.

The file has two combinational read ports and one synchronous main write port. A separate auto-modify port steps one register up or down in the same cycle as a main write. An instruction decoder uses it for post-increment and pre-decrement addressing. Register 7 is the hardware stack pointer, and its value is always visible on a dedicated output. A push is a word store together with a word decrement of register 7 on the auto-modify port. A pop is a word load together with a word increment.

Top module: `rf_alias_regfile`

## Requirements
- R1: An active-low reset clears all eight registers to 0x0000.
- R2: When a read port's word flag is 1, the port returns the full 16-bit register selected by selector bits 2:0, and selector bit 3 is ignored.
- R3: When a read port's word flag is 0, selector bit 3 picks the half: 0 selects bits 15:8 and 1 selects bits 7:0. The byte is returned on data bits 7:0, and data bits 15:8 are 0.
- R4: A main word write (write enable 1, word flag 1) replaces the whole selected register, and the new value is readable from the next cycle.
- R5: A main byte write (word flag 0) loads write data bits 7:0 into the half chosen by selector bit 3, using the same encoding as R3. The other half of that register keeps its value.
- R6: A read in the same cycle as a write to the same register returns the value held before the write; there is no forwarding.
- R7: An auto-modify request adds 1 (byte flag) or 2 (word flag) to the selected register, or subtracts it when the decrement input is 1. The result wraps modulo 65536 and appears in the next cycle.
- R8: If the main write and the auto-modify target the same register in one cycle, only the main write takes effect. If they target different registers, both take effect.
- R9: The stack-pointer output always equals register 7.
- R10: In a cycle with neither a main write nor an auto-modify, every register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_sel | input | 4 | Read port A selector (bit 3 = half, bits 2:0 = register) |
| rd_a_word | input | 1 | Read port A width: 1 word, 0 byte |
| rd_a_data | output | 16 | Read port A data |
| rd_b_sel | input | 4 | Read port B selector |
| rd_b_word | input | 1 | Read port B width |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Main write enable |
| wr_sel | input | 4 | Main write selector |
| wr_word | input | 1 | Main write width: 1 word, 0 byte |
| wr_data | input | 16 | Main write data (bits 7:0 used for byte writes) |
| am_en | input | 1 | Auto-modify enable |
| am_reg | input | 3 | Auto-modify register index |
| am_word | input | 1 | Auto-modify step size: 1 gives 2, 0 gives 1 |
| am_dec | input | 1 | Auto-modify direction: 1 decrement, 0 increment |
| sp_data | output | 16 | Current value of register 7 |

## Verification
The assertions assume that every control input has a known 0 or 1 value on each rising edge while reset is released. They also assume that reset is asserted from time zero, so the first sampled rise of rst_n follows a clearing reset. The stimulus meets both assumptions. It drives all inputs from the bench on the falling edge, starts with reset low and keeps it low for several cycles. The random phase draws every field from the full range of its encoding. As a result, same-register collisions between the write, auto-modify and read ports occur often, as well as wraps through zero.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_WORD = 1'b1
    } acc_width_e;

    // Auto-modify distance: one byte or one word.
    function automatic int unsigned step_size(input acc_width_e w);
        return (w == ACC_WORD) ? 2 : 1;
    endfunction

endpackage

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
module rf_read_port #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
    input  logic [$clog2(NUM_REGS):0]       sel_i,
    input  logic                            word_i,
    output logic [DATA_W-1:0]               data_o
);
    localparam int IDX_W  = $clog2(NUM_REGS);
    localparam int BYTE_W = DATA_W / 2;

    logic [DATA_W-1:0] word_v;

    always_comb begin
        word_v = regs_i[sel_i[IDX_W-1:0]];
        if (word_i) begin
            data_o = word_v;
        end else if (sel_i[IDX_W]) begin
            data_o = {{BYTE_W{1'b0}}, word_v[BYTE_W-1:0]};
        end else begin
            data_o = {{BYTE_W{1'b0}}, word_v[DATA_W-1:BYTE_W]};
        end
    end
endmodule

// File: rtl/rf_write_merge.sv
`timescale 1ns/1ps
module rf_write_merge #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              word_i,
    input  logic              low_i,
    output logic [DATA_W-1:0] new_o
);
    localparam int BYTE_W = DATA_W / 2;

    always_comb begin
        if (word_i) begin
            new_o = data_i;
        end else if (low_i) begin
            new_o = {old_i[DATA_W-1:BYTE_W], data_i[BYTE_W-1:0]};
        end else begin
            new_o = {data_i[BYTE_W-1:0], old_i[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/rf_step_unit.sv
`timescale 1ns/1ps
module rf_step_unit #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic              word_i,
    input  logic              dec_i,
    output logic [DATA_W-1:0] val_o
);
    import rf_pkg::*;

    logic [DATA_W-1:0] amt;

    always_comb begin
        amt   = DATA_W'(step_size(word_i ? ACC_WORD : ACC_BYTE));
        val_o = dec_i ? (val_i - amt) : (val_i + amt);
    end
endmodule

// File: rtl/rf_alias_regfile.sv
`timescale 1ns/1ps
module rf_alias_regfile #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(NUM_REGS):0] rd_a_sel,
    input  logic                      rd_a_word,
    output logic [DATA_W-1:0]         rd_a_data,
    input  logic [$clog2(NUM_REGS):0] rd_b_sel,
    input  logic                      rd_b_word,
    output logic [DATA_W-1:0]         rd_b_data,
    input  logic                      wr_en,
    input  logic [$clog2(NUM_REGS):0] wr_sel,
    input  logic                      wr_word,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      am_en,
    input  logic [$clog2(NUM_REGS)-1:0] am_reg,
    input  logic                      am_word,
    input  logic                      am_dec,
    output logic [DATA_W-1:0]         sp_data
);
    localparam int IDX_W  = $clog2(NUM_REGS);
    localparam int SEL_W  = IDX_W + 1;
    localparam int NUM_RD = 2;
    localparam int SP_IDX = NUM_REGS - 1;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_merged;
    logic [DATA_W-1:0] am_stepped;
    logic              am_blocked;

    assign wr_idx = wr_sel[IDX_W-1:0];

    rf_write_merge #(.DATA_W(DATA_W)) u_merge (
        .old_i  (st_q.regs[wr_idx]),
        .data_i (wr_data),
        .word_i (wr_word),
        .low_i  (wr_sel[IDX_W]),
        .new_o  (wr_merged)
    );

    rf_step_unit #(.DATA_W(DATA_W)) u_step (
        .val_i  (st_q.regs[am_reg]),
        .word_i (am_word),
        .dec_i  (am_dec),
        .val_o  (am_stepped)
    );

    // Read ports share one implementation.
    logic [NUM_RD-1:0][SEL_W-1:0]  rd_sel;
    logic [NUM_RD-1:0]             rd_word;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data;

    assign rd_sel  = {rd_b_sel, rd_a_sel};
    assign rd_word = {rd_b_word, rd_a_word};

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd (
            .regs_i (st_q.regs),
            .sel_i  (rd_sel[p]),
            .word_i (rd_word[p]),
            .data_o (rd_data[p])
        );
    end

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign sp_data   = st_q.regs[SP_IDX];

    // Next-state: auto-modify first, main write overrides on collision.
    always_comb begin
        st_d       = st_q;
        am_blocked = wr_en && (wr_idx == am_reg);
        if (am_en && !am_blocked) begin
            st_d.regs[am_reg] = am_stepped;
        end
        if (wr_en) begin
            st_d.regs[wr_idx] = wr_merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rf_alias_checker.sv
`timescale 1ns/1ps
module rf_alias_checker #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [$clog2(NUM_REGS):0]   rd_a_sel,
    input logic                        rd_a_word,
    input logic [DATA_W-1:0]           rd_a_data,
    input logic                        wr_en,
    input logic [$clog2(NUM_REGS):0]   wr_sel,
    input logic                        wr_word,
    input logic [DATA_W-1:0]           wr_data,
    input logic                        am_en,
    input logic [$clog2(NUM_REGS)-1:0] am_reg,
    input logic                        am_word,
    input logic                        am_dec,
    input logic [DATA_W-1:0]           sp_data
);
    localparam int IDX_W  = $clog2(NUM_REGS);
    localparam int BYTE_W = DATA_W / 2;
    localparam logic [IDX_W-1:0] SP = IDX_W'(NUM_REGS - 1);

    logic              wr_hits_sp;
    logic              am_hits_sp;
    logic [DATA_W-1:0] sp_step_exp;

    assign wr_hits_sp  = wr_en && (wr_sel[IDX_W-1:0] == SP);
    assign am_hits_sp  = am_en && (am_reg == SP);
    assign sp_step_exp = am_dec ? (sp_data - (am_word ? DATA_W'(2) : DATA_W'(1)))
                                : (sp_data + (am_word ? DATA_W'(2) : DATA_W'(1)));

    // R1
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sp_data == '0);

    // R7 and R9: stack pointer stepping
    a_r7_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (am_hits_sp && !wr_hits_sp) |=> sp_data == $past(sp_step_exp));

    // R8: main write wins over auto-modify on the stack pointer
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hits_sp && wr_word) |=> sp_data == $past(wr_data));

    // R5: byte write to upper half leaves lower half
    a_r5_byte_half: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hits_sp && !wr_word && !wr_sel[IDX_W]) |=>
            (sp_data[DATA_W-1:BYTE_W] == $past(wr_data[BYTE_W-1:0]))
            && (sp_data[BYTE_W-1:0] == $past(sp_data[BYTE_W-1:0])));

    // R10
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !am_en) |=> $stable(sp_data));

    // R2 and R9: word read of register 7 agrees with the stack view
    a_r2_sp_view: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_word && rd_a_sel[IDX_W-1:0] == SP) |-> rd_a_data == sp_data);

    // R3: byte reads never drive the upper lane
    a_r3_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_a_word |-> rd_a_data[DATA_W-1:BYTE_W] == '0);
endmodule

bind rf_alias_regfile rf_alias_checker #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
) u_chk (.*);

// File: tb/sim_rf_alias_regfile.sv
`timescale 1ns/1ps
module sim_rf_alias_regfile;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
    logic        rd_a_word = 1'b0, rd_b_word = 1'b0, wr_en = 1'b0, wr_word = 1'b0;
    logic [15:0] wr_data = '0;
    logic        am_en = 1'b0, am_word = 1'b0, am_dec = 1'b0;
    logic [2:0]  am_reg = '0;
    logic [15:0] rd_a_data, rd_b_data, sp_data;

    rf_alias_regfile u0 (.*);

    logic [15:0] m [8];
    int vec = 0;
    int bad = 0;

    function automatic logic [15:0] exp_rd(logic [3:0] s, logic w);
        logic [15:0] v = m[s[2:0]];
        if (w) return v;
        return s[3] ? {8'h00, v[7:0]} : {8'h00, v[15:8]};
    endfunction

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        vec++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    // One cycle: drive, check current state, advance the model.
    task automatic cyc(string tag, logic [3:0] sa, logic wa, logic [3:0] sb, logic wb,
                       logic we, logic [3:0] ws, logic ww, logic [15:0] wd,
                       logic ae, logic [2:0] ar, logic aw, logic ad);
        string ta, tb;
        logic [15:0] amt;
        @(negedge clk);
        rd_a_sel = sa; rd_a_word = wa; rd_b_sel = sb; rd_b_word = wb;
        wr_en = we; wr_sel = ws; wr_word = ww; wr_data = wd;
        am_en = ae; am_reg = ar; am_word = aw; am_dec = ad;
        #1;
        ta = (tag != "") ? tag : ((we && ws[2:0] == sa[2:0]) ? "R6" : (wa ? "R2" : "R3"));
        tb = (we && ws[2:0] == sb[2:0]) ? "R6" : (wb ? "R2" : "R3");
        chk(ta, rd_a_data, exp_rd(sa, wa));
        chk(tb, rd_b_data, exp_rd(sb, wb));
        chk("R9", sp_data, m[7]);
        amt = aw ? 16'd2 : 16'd1;
        if (ae && !(we && ws[2:0] == ar))
            m[ar] = ad ? m[ar] - amt : m[ar] + amt;
        if (we) begin
            if (ww) m[ws[2:0]] = wd;
            else if (ws[3]) m[ws[2:0]][7:0] = wd[7:0];
            else m[ws[2:0]][15:8] = wd[7:0];
        end
    endtask

    task automatic rd(string tag, logic [3:0] s, logic w);
        cyc(tag, s, w, 4'd0, 1'b1, 1'b0, 4'd0, 1'b0, 16'h0, 1'b0, 3'd0, 1'b0, 1'b0);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < 8; i++) m[i] = 16'h0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: all registers clear after reset
        for (int i = 0; i < 8; i++) rd("R1", 4'(i), 1'b1);

        // R4: word write, then read with bit 3 set (R2 ignores it)
        cyc("", 4'd0, 1, 4'd0, 1, 1, 4'd3, 1, 16'hA5C3, 0, 3'd0, 0, 0);
        rd("R4", 4'd3, 1'b1);
        rd("R2", 4'b1011, 1'b1);

        // R5: byte writes to each half
        cyc("", 4'd0, 1, 4'd0, 1, 1, 4'b0011, 0, 16'hFF7E, 0, 3'd0, 0, 0);
        rd("R5", 4'd3, 1'b1);
        cyc("", 4'd0, 1, 4'd0, 1, 1, 4'b1011, 0, 16'h2211, 0, 3'd0, 0, 0);
        rd("R5", 4'd3, 1'b1);
        rd("R3", 4'b0011, 1'b0);
        rd("R3", 4'b1011, 1'b0);

        // R6: read the register being written this cycle
        cyc("R6", 4'd2, 1, 4'b1010, 0, 1, 4'd2, 1, 16'h1234, 0, 3'd0, 0, 0);
        rd("R6", 4'd2, 1'b1);

        // R7: push from zero wraps, byte steps wrap back to zero
        cyc("", 4'd0, 1, 4'd0, 1, 0, 4'd0, 0, 16'h0, 1, 3'd7, 1, 1);
        rd("R7", 4'd7, 1'b1);
        cyc("", 4'd0, 1, 4'd0, 1, 0, 4'd0, 0, 16'h0, 1, 3'd7, 0, 0);
        rd("R7", 4'd7, 1'b1);
        cyc("", 4'd0, 1, 4'd0, 1, 0, 4'd0, 0, 16'h0, 1, 3'd7, 0, 0);
        rd("R7", 4'd7, 1'b1);

        // R8: collision, then disjoint targets
        cyc("", 4'd0, 1, 4'd0, 1, 1, 4'd5, 1, 16'h4000, 1, 3'd5, 1, 0);
        rd("R8", 4'd5, 1'b1);
        cyc("", 4'd0, 1, 4'd0, 1, 1, 4'b1101, 0, 16'h0099, 1, 3'd5, 1, 1);
        rd("R8", 4'd5, 1'b1);
        cyc("", 4'd0, 1, 4'd0, 1, 1, 4'd5, 1, 16'h0001, 1, 3'd6, 0, 1);
        rd("R8", 4'd5, 1'b1);
        rd("R8", 4'd6, 1'b1);

        // R10: idle cycles hold state
        rd("", 4'd0, 1'b1);
        rd("R10", 4'd5, 1'b1);
        rd("R10", 4'd3, 1'b1);

        // Constrained random phase
        void'($urandom(32'd20240607));
        for (int n = 0; n < 4000; n++) begin
            cyc("", 4'($urandom), 1'($urandom), 4'($urandom), 1'($urandom),
                1'($urandom), 4'($urandom), 1'($urandom), 16'($urandom),
                1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
        end
        for (int i = 0; i < 8; i++) rd("R10", 4'(i), 1'b1);

        summary();
    end
endmodule